// File: doc/BRIEF.md
# Addressed Serial Display Loader

This block takes framed bit streams from a host controller over three wires: an enable, a shift clock and a data line. All three are sampled by the fast system clock after two-flop synchronisers. While the enable is low, the host shifts in an 8-bit device address. When the enable rises, the block compares that address with its own. A matching frame then shifts in a 48-bit group. The group is committed when the enable falls, but only if the group length is exactly right.

Each group holds 36 display bits, 7 control bits, 3 padding bits and a 2-bit direction code. The direction code chooses which slice of the 136-bit display bitmap the group overwrites. Only the group with direction code 0 also updates the control fields: the output-port assignment code, the bias select, the segment blanking and the low-power request. A host can refresh one, two, three or all four slices. The slices it does not send keep their values. The shift clock may rest high or low between frames.

Top module: `lcdl_loader`

## Requirements
- R1: After synchronous reset, `disp_map` is all zeros and `port_mode`, `bias_half`, `seg_blank` and `low_power` are 0.
- R2: The address is the last 8 data bits clocked in on rising `ld_clk` edges while `ld_en` is low, first bit = address bit 0. A frame whose address is not 0x46 changes no output.
- R3: A group is committed only when `ld_en` falls after exactly 48 rising `ld_clk` edges with `ld_en` high. A frame of 47 or of 49 bits changes no output.
- R4: Group bit i is the i-th data bit after `ld_en` rises (i from 0). Bits 46 (LSB) and 47 form a direction code k. A committed group writes its bits 0..35 to `disp_map[36k +: 36]` for k = 0, 1, 2, and leaves every other slice unchanged.
- R5: For direction code 3, group bits 0..27 go to `disp_map[135:108]`, and group bits 28..35 are ignored.
- R6: Only a committed group with direction code 0 updates the control fields: bits 39..36 go to `port_mode` (bit 36 = LSB), bit 40 to `bias_half`, bit 41 to `seg_blank` and bit 42 to `low_power`. Bits 43..45 are padding. Groups with codes 1..3 leave the control fields unchanged, whatever their bits 36..45 hold.
- R7: Frames decode the same whether `ld_clk` rests low or high around the enable edges.
- R8: The outputs change on the 4th rising `clk` edge after `ld_en` falls, counted from the first edge at which the low level is sampled. They change at no other time. Every level on `ld_en`, `ld_clk` and `ld_dat` is held for at least 3 `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Host frame enable (asynchronous) |
| ld_clk | input | 1 | Host shift clock (asynchronous) |
| ld_dat | input | 1 | Host serial data (asynchronous) |
| disp_map | output | 136 | Display bitmap |
| port_mode | output | 4 | Output-port assignment code |
| bias_half | output | 1 | Bias select |
| seg_blank | output | 1 | Segment blanking request |
| low_power | output | 1 | Low-power request |

## Verification
The assertions check several things on every cycle. A commit pulse lasts one cycle and needs both a matched address and a count of exactly 48. The bitmap changes only right after a commit. The control fields change only right after a commit whose direction code is 0.

Other properties can only be shown by the scenarios, with a behavioural model compared on every clock. These are the mapping of group bits onto each slice, the truncated fourth slice, the ignored control positions in groups 1 to 3, rejected addresses and lengths, and decoding with the shift clock resting high.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;
  localparam int CTRL_LSB  = 36;
  localparam int CTRL_BITS = 7;

  typedef struct packed {
    logic       low_power;
    logic       seg_blank;
    logic       bias_half;
    logic [3:0] port_mode;
  } lcdl_ctrl_t;
endpackage

// File: rtl/lcdl_sync.sv
module lcdl_sync #(
  parameter int LANES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-2:0], din[l]};
    end
    assign dout[l] = pipe[STAGES-1];
  end
endmodule

// File: rtl/lcdl_rx.sv
module lcdl_rx #(
  parameter int          ADDR_BITS  = 8,
  parameter logic [7:0]  DEV_ADDR   = 8'h46,
  parameter int          GROUP_BITS = 48,
  localparam int         CNT_W      = $clog2(GROUP_BITS + 2),
  localparam int         IDX_W      = $clog2(GROUP_BITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en_s,
  input  logic                  clk_s,
  input  logic                  dat_s,
  output logic                  commit_q,
  output logic [GROUP_BITS-1:0] frame_q,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  addr_hit
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(GROUP_BITS);

  logic                 en_q, ck_q;
  logic [ADDR_BITS-1:0] addr_sr;
  logic                 en_rise, en_fall, ck_rise;

  assign en_rise = en_s & ~en_q;
  assign en_fall = ~en_s & en_q;
  assign ck_rise = clk_s & ~ck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ck_q     <= 1'b0;
      addr_sr  <= '0;
      addr_hit <= 1'b0;
      bit_cnt  <= '0;
      frame_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      en_q     <= en_s;
      ck_q     <= clk_s;
      commit_q <= 1'b0;
      if (en_rise) begin
        addr_hit <= (addr_sr == DEV_ADDR[ADDR_BITS-1:0]);
        bit_cnt  <= '0;
      end else if (ck_rise) begin
        if (!en_s) begin
          addr_sr <= {dat_s, addr_sr[ADDR_BITS-1:1]};
        end else if (addr_hit && bit_cnt <= FULL_CNT) begin
          if (bit_cnt < FULL_CNT) frame_q[bit_cnt[IDX_W-1:0]] <= dat_s;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (en_fall) begin
        commit_q <= addr_hit && (bit_cnt == FULL_CNT);
        addr_hit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lcdl_store.sv
module lcdl_store
  import lcdl_pkg::*;
#(
  parameter int  GROUP_BITS = 48,
  parameter int  SLICE_BITS = 36,
  parameter int  DISP_BITS  = 136,
  parameter int  NUM_SLICES = 4,
  localparam int DIR_W      = $clog2(NUM_SLICES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commit,
  input  logic [GROUP_BITS-1:0] frame,
  output logic [DISP_BITS-1:0]  disp_map,
  output lcdl_ctrl_t            ctrl_q
);
  logic [DIR_W-1:0] dir;
  logic             pad_unused;

  assign dir        = frame[GROUP_BITS-1 -: DIR_W];
  assign pad_unused = ^frame[GROUP_BITS-DIR_W-1 : CTRL_LSB+CTRL_BITS];

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    localparam int REM = DISP_BITS - k * SLICE_BITS;
    localparam int W   = (REM < SLICE_BITS) ? REM : SLICE_BITS;
    logic [W-1:0] slice_q;
    always_ff @(posedge clk) begin
      if (rst)                               slice_q <= '0;
      else if (commit && dir == DIR_W'(k))   slice_q <= frame[W-1:0];
    end
    assign disp_map[k*SLICE_BITS +: W] = slice_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                         ctrl_q <= '0;
    else if (commit && dir == '0)    ctrl_q <= lcdl_ctrl_t'(frame[CTRL_LSB +: CTRL_BITS]);
  end
endmodule

// File: rtl/lcdl_loader.sv
module lcdl_loader
  import lcdl_pkg::*;
#(
  parameter int         ADDR_BITS   = 8,
  parameter logic [7:0] DEV_ADDR    = 8'h46,
  parameter int         GROUP_BITS  = 48,
  parameter int         SLICE_BITS  = 36,
  parameter int         DISP_BITS   = 136,
  parameter int         SYNC_STAGES = 2,
  localparam int        NUM_SLICES  = (DISP_BITS + SLICE_BITS - 1) / SLICE_BITS,
  localparam int        DIR_W       = $clog2(NUM_SLICES),
  localparam int        CNT_W       = $clog2(GROUP_BITS + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_en,
  input  logic                 ld_clk,
  input  logic                 ld_dat,
  output logic [DISP_BITS-1:0] disp_map,
  output logic [3:0]           port_mode,
  output logic                 bias_half,
  output logic                 seg_blank,
  output logic                 low_power
);
  logic [2:0]            pins_s;
  logic                  rx_commit, rx_hit;
  logic [GROUP_BITS-1:0] rx_frame;
  logic [CNT_W-1:0]      rx_cnt;
  logic [DIR_W-1:0]      grp_dir;
  lcdl_ctrl_t            ctrl;

  lcdl_sync #(.LANES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ld_dat, ld_clk, ld_en}),
    .dout(pins_s)
  );

  lcdl_rx #(.ADDR_BITS(ADDR_BITS), .DEV_ADDR(DEV_ADDR), .GROUP_BITS(GROUP_BITS)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .en_s    (pins_s[0]),
    .clk_s   (pins_s[1]),
    .dat_s   (pins_s[2]),
    .commit_q(rx_commit),
    .frame_q (rx_frame),
    .bit_cnt (rx_cnt),
    .addr_hit(rx_hit)
  );

  lcdl_store #(.GROUP_BITS(GROUP_BITS), .SLICE_BITS(SLICE_BITS), .DISP_BITS(DISP_BITS),
               .NUM_SLICES(NUM_SLICES)) u_store (
    .clk     (clk),
    .rst     (rst),
    .commit  (rx_commit),
    .frame   (rx_frame),
    .disp_map(disp_map),
    .ctrl_q  (ctrl)
  );

  assign grp_dir   = rx_frame[GROUP_BITS-1 -: DIR_W];
  assign port_mode = ctrl.port_mode;
  assign bias_half = ctrl.bias_half;
  assign seg_blank = ctrl.seg_blank;
  assign low_power = ctrl.low_power;
endmodule

// File: rtl/lcdl_loader_chk.sv
module lcdl_loader_chk #(
  parameter int GROUP_BITS = 48,
  parameter int DISP_BITS  = 136,
  parameter int CNT_W      = 6,
  parameter int DIR_W      = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 commit,
  input logic                 addr_hit,
  input logic [CNT_W-1:0]     bit_cnt,
  input logic [DIR_W-1:0]     dir,
  input logic [DISP_BITS-1:0] disp_map,
  input logic [6:0]           ctrl_vec
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(GROUP_BITS);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (disp_map == '0 && ctrl_vec == '0));

  // R2
  commit_addr_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(addr_hit));

  // R3
  commit_len_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> bit_cnt == FULL_CNT);

  // R3
  commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R8
  disp_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(disp_map) |-> $past(commit));

  // R6
  ctrl_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_vec) |-> ($past(commit) && $past(dir) == '0));
endmodule

bind lcdl_loader lcdl_loader_chk #(
  .GROUP_BITS(GROUP_BITS), .DISP_BITS(DISP_BITS), .CNT_W(CNT_W), .DIR_W(DIR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .commit  (rx_commit),
  .addr_hit(rx_hit),
  .bit_cnt (rx_cnt),
  .dir     (grp_dir),
  .disp_map(disp_map),
  .ctrl_vec({low_power, seg_blank, bias_half, port_mode})
);

// File: tb/lcdl_loader_tb.sv
module lcdl_loader_tb;
  localparam int PH = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ld_en = 1'b0, ld_clk = 1'b0, ld_dat = 1'b0;
  logic [135:0] disp_map;
  logic [3:0]   port_mode;
  logic         bias_half, seg_blank, low_power;

  logic [135:0] exp_disp = '0;
  logic [6:0]   exp_ctrl = '0;
  int           n_chk = 0, n_fail = 0;
  bit           cmp_on = 1'b0;
  string        cur_req = "R1";

  always #2 clk = ~clk;

  lcdl_loader u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_clk(ld_clk), .ld_dat(ld_dat),
    .disp_map(disp_map), .port_mode(port_mode), .bias_half(bias_half),
    .seg_blank(seg_blank), .low_power(low_power)
  );

  always @(negedge clk) begin
    if (cmp_on) begin
      n_chk++;
      if (disp_map !== exp_disp || {low_power, seg_blank, bias_half, port_mode} !== exp_ctrl) begin
        n_fail++;
        $display("FAIL %s cycle compare: actual disp=%h ctrl=%b expected disp=%h ctrl=%b",
                 cur_req, disp_map, {low_power, seg_blank, bias_half, port_mode}, exp_disp, exp_ctrl);
      end
    end
  end

  task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_group(input logic [1:0] dir, input logic [35:0] d,
                                           input logic [6:0] c, input logic [2:0] pad);
    logic [63:0] g = '0;
    g[35:0] = d; g[42:36] = c; g[45:43] = pad; g[47:46] = dir;
    return g;
  endfunction

  task automatic model(input logic [7:0] addr, input logic [63:0] b, input int n);
    int w;
    if (addr != 8'h46 || n != 48) return;
    w = (b[47:46] == 2'd3) ? 28 : 36;
    for (int i = 0; i < w; i++) exp_disp[36*b[47:46] + i] = b[i];
    if (b[47:46] == 2'd0) exp_ctrl = b[42:36];
  endtask

  task automatic hold();
    repeat (PH) @(negedge clk);
  endtask

  task automatic shift_bit(input logic v, input bit hi);
    if (hi) begin
      ld_clk = 1'b0; ld_dat = v; hold(); ld_clk = 1'b1; hold();
    end else begin
      ld_dat = v; hold(); ld_clk = 1'b1; hold(); ld_clk = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] addr, input logic [63:0] b, input int n, input bit hi);
    ld_clk = hi; hold();
    for (int i = 0; i < 8; i++) shift_bit(addr[i], hi);
    hold(); ld_en = 1'b1; hold();
    for (int i = 0; i < n; i++) shift_bit(b[i], hi);
    hold(); ld_en = 1'b0;
    repeat (4) @(posedge clk);
    model(addr, b, n);
    hold();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R8: actual run still busy expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 bitmap", disp_map, '0);
    check("R1 control", {129'd0, low_power, seg_blank, bias_half, port_mode}, '0);
    cmp_on = 1'b1;

    // R4 R6: direction 0 with control
    cur_req = "R4 R6 dir0";
    send(8'h46, mk_group(2'd0, 36'hA5C3_1F0E7, 7'b101_1011, 3'b111), 48, 1'b0);
    check("R6 port_mode", {132'd0, port_mode}, 136'hB);
    check("R6 flags", {133'd0, low_power, seg_blank, bias_half}, 136'h5);

    // R4: other slices; R6: control positions ignored there; R5: truncated slice
    cur_req = "R4 R6 dir1";
    send(8'h46, mk_group(2'd1, 36'h1_2345_6789, 7'h7F, 3'b101), 48, 1'b0);
    cur_req = "R4 dir2";
    send(8'h46, mk_group(2'd2, 36'hF_EDCB_A987, 7'h55, 3'b010), 48, 1'b0);
    cur_req = "R5 dir3";
    send(8'h46, mk_group(2'd3, 36'hF_F123_4567, 7'h2A, 3'b000), 48, 1'b0);
    check("R5 top slice", {108'd0, disp_map[135:108]}, {108'd0, 28'h123_4567});
    check("R6 control kept", {129'd0, low_power, seg_blank, bias_half, port_mode}, {129'd0, 7'b101_1011});

    // R2: wrong addresses
    cur_req = "R2 addr";
    send(8'h47, mk_group(2'd0, 36'h0, 7'h00, 3'b0), 48, 1'b0);
    send(8'h64, mk_group(2'd1, 36'h0, 7'h00, 3'b0), 48, 1'b0);
    send(8'hC6, mk_group(2'd2, 36'h0, 7'h00, 3'b0), 48, 1'b0);
    check("R2 slice1 kept", {100'd0, disp_map[71:36]}, {100'd0, 36'h1_2345_6789});

    // R3: wrong lengths
    cur_req = "R3 length";
    send(8'h46, mk_group(2'd0, 36'h0, 7'h00, 3'b0), 47, 1'b0);
    send(8'h46, mk_group(2'd0, 36'h0, 7'h00, 3'b0) | (64'd1 << 48), 49, 1'b0);
    check("R3 slice0 kept", {100'd0, disp_map[35:0]}, {100'd0, 36'hA5C3_1F0E7});

    // R7: shift clock resting high
    cur_req = "R7 idle high";
    send(8'h46, mk_group(2'd2, 36'h0_0F0F_00FF, 7'h00, 3'b0), 48, 1'b1);
    send(8'h46, mk_group(2'd0, 36'h3_3333_3333, 7'b010_0110, 3'b0), 48, 1'b1);
    check("R7 slice2", {100'd0, disp_map[107:72]}, {100'd0, 36'h0_0F0F_00FF});
    check("R7 control", {129'd0, low_power, seg_blank, bias_half, port_mode}, {129'd0, 7'b010_0110});
    send(8'h45, mk_group(2'd1, 36'h0, 7'h00, 3'b0), 48, 1'b1);

    // R8 and R4 partial update: one slice back in low-rest mode
    cur_req = "R8 R4 partial";
    send(8'h46, mk_group(2'd1, 36'hC_0000_0003, 7'h00, 3'b0), 48, 1'b0);
    check("R4 slice0 untouched", {100'd0, disp_map[35:0]}, {100'd0, 36'h3_3333_3333});
    check("R4 slice1 new", {100'd0, disp_map[71:36]}, {100'd0, 36'hC_0000_0003});

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule